// File: doc/BRIEF.md
# Programmable Event Counter Bank

This block holds a set of performance counters that software programs through a single-cycle 32-bit register port. Every clock, each counter looks at one bit of an incoming event vector, chosen by an 8-bit code. The counter advances by one when that bit is high, the global run bit and its own enable bit are set, and a shared qualifier passes. The qualifier can require a match on an 11-bit source identifier under a bit mask, and it can also require an asserted tag input.

When a counter rolls over from all ones to zero, it latches a status flag. The flag is cleared by writing a one to a separate clear register. The interrupt line is raised when any latched flag is not masked. One parameter chooses between two shapes: sixteen counters of 48 bits, or eight counters of 64 bits. Each counter is seen as two 32-bit words.

Register map (byte offsets): run control 0x000, counter enables 0x004, interrupt mask 0x008, interrupt status 0x00C (read only), status clear 0x010 (reads zero), filter 0x014, event-select registers from 0x040 in steps of 4, counter slots from 0x100.

Top module: `evctr_top`

## Requirements
- R1: After reset, every counter reads 0. The run, enable and status registers read 0. Every event-select register reads 0xFFFFFFFF, the mask register reads ones in its low N bits (N = counter count), and irq is 0.
- R2: Counter i increments by one on each clock edge where run bit 0 is 1, enable bit i is 1, the event bit picked by its code is 1, and the filter qualifier passes.
- R3: If run bit 0 is 0, or enable bit i is 0, counter i holds its value.
- R4: The code of counter i lives in event-select register 0x040+4*(i/4), bits 8*(i%4)+7 down to 8*(i%4), and picks event bit number code. Code 0xFF, and any code at or above the event-vector width, never counts.
- R5: Counter i sits at 0x100+8*i, with the low word at +0 and the high word at +4. A register write to a counter word in the same cycle as a qualified event stores the written value, and the increment is dropped.
- R6: In the 48-bit shape, bits 63:48 of a counter read as 0, and writes to them are ignored.
- R7: When a counter increments from all ones of its width, it becomes 0 and sets status bit i.
- R8: Writing 1 to bit i of the clear register clears status bit i, and written zeros leave bits unchanged. A rollover in the same cycle as its clear leaves the bit set.
- R9: irq goes to 1 one cycle after any status bit i is 1 while mask bit i is 0. Mask bit 1 suppresses counter i.
- R10: The filter register has enable at bit 2, an 11-bit command ID at 16:6, an 11-bit ID mask at 30:20 and the tag enable at bit 31; other bits read 0. With the enable set, an event passes only if src_id equals the command ID on every bit where the mask is 1.
- R11: With bit 31 of the filter set, an event passes only while trace_tag is 1.
- R12: Read data appears on reg_rdata one cycle after reg_rd, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, single cycle |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe, single cycle |
| reg_rdata | output | 32 | Registered read data |
| ev_pulse | input | EV_W | Per-cycle event pulses |
| src_id | input | 11 | Source identifier of the current events |
| trace_tag | input | 1 | Tag carried with the current events |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds two copies of the block side by side on the same stimulus. One uses the default 16-counter, 48-bit shape and the other the 8-counter, 64-bit shape, both with a 64-bit event vector. A single write of all ones to a counter's high word therefore shows the truncation and ignored upper bits of the narrow shape next to the full word of the wide one, and rollover is exercised at both widths. The 64-bit event vector makes a code of 0x40 land past the last event bit, so the rule that out-of-range codes never count is tested in both copies.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_RUN  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CEN  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_FILT = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_SEL  = 12'h040;
  localparam logic [3:0]        CNT_PAGE = 4'h1;

  localparam logic [7:0] CODE_NONE = 8'hFF;
  localparam int unsigned ID_W = 11;

  typedef struct packed {
    logic            tag_en;
    logic [ID_W-1:0] id_msk;
    logic [ID_W-1:0] id_cmd;
    logic            id_en;
  } filt_t;

  function automatic int unsigned num_cnt(input bit wide);
    return wide ? 8 : 16;
  endfunction

  function automatic int unsigned cnt_bits(input bit wide);
    return wide ? 64 : 48;
  endfunction
endpackage

// File: rtl/evctr_filter.sv
module evctr_filter
  import evctr_pkg::*;
(
  input  filt_t           filt,
  input  logic [ID_W-1:0] src_id,
  input  logic            trace_tag,
  output logic            pass
);
  logic id_ok;
  logic tag_ok;

  always_comb begin
    id_ok  = !filt.id_en || (((src_id ^ filt.id_cmd) & filt.id_msk) == '0);
    tag_ok = !filt.tag_en || trace_tag;
    pass   = id_ok && tag_ok;
  end
endmodule

// File: rtl/evctr_counter.sv
module evctr_counter #(
  parameter int unsigned CW = 48
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inc,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [63:0] value,
  output logic        wrap
);
  localparam int unsigned HI_W = CW - 32;

  logic [CW-1:0] cnt;
  logic          sw_wr;

  assign sw_wr = wr_lo || wr_hi;
  assign wrap  = inc && !sw_wr && (&cnt);
  assign value = 64'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (sw_wr) begin
      if (wr_lo) cnt[31:0]    <= wdata;
      if (wr_hi) cnt[CW-1:32] <= wdata[HI_W-1:0];
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (value == 64'd0));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc && !sw_wr) |=> $stable(value));
endmodule

// File: rtl/evctr_regs.sv
module evctr_regs
  import evctr_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic [N-1:0]      wrap,
  output logic              run,
  output logic [N-1:0]      cnt_en,
  output logic [N-1:0]      irq_mask,
  output logic [N-1:0]      irq_stat,
  output filt_t             filt,
  output logic [N-1:0][7:0] codes
);
  logic [N-1:0] clr_bits;

  assign clr_bits = (reg_wr && reg_addr == OFS_CLR) ? reg_wdata[N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      cnt_en   <= '0;
      irq_mask <= '1;
      irq_stat <= '0;
      filt     <= '0;
    end else begin
      if (reg_wr && reg_addr == OFS_RUN)  run      <= reg_wdata[0];
      if (reg_wr && reg_addr == OFS_CEN)  cnt_en   <= reg_wdata[N-1:0];
      if (reg_wr && reg_addr == OFS_MASK) irq_mask <= reg_wdata[N-1:0];
      if (reg_wr && reg_addr == OFS_FILT) begin
        filt.id_en  <= reg_wdata[2];
        filt.id_cmd <= reg_wdata[16:6];
        filt.id_msk <= reg_wdata[30:20];
        filt.tag_en <= reg_wdata[31];
      end
      irq_stat <= (irq_stat & ~clr_bits) | wrap;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_code
    localparam logic [ADDR_W-1:0] SEL_A = OFS_SEL + ADDR_W'(4 * (i / 4));
    logic [7:0] code_q;
    always_ff @(posedge clk) begin
      if (rst) code_q <= CODE_NONE;
      else if (reg_wr && reg_addr == SEL_A) code_q <= reg_wdata[8*(i%4) +: 8];
    end
    assign codes[i] = code_q;
  end

  // R8
  clr_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFS_CLR) |=>
      ((irq_stat & $past(reg_wdata[N-1:0] & ~wrap)) == '0));

  // R7
  stat_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|wrap) |=> ((irq_stat & $past(wrap)) == $past(wrap)));
endmodule

// File: rtl/evctr_top.sv
module evctr_top
  import evctr_pkg::*;
#(
  parameter bit          WIDE_CNT = 1'b0,
  parameter int unsigned EV_W     = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  input  logic [EV_W-1:0]   ev_pulse,
  input  logic [ID_W-1:0]   src_id,
  input  logic              trace_tag,
  output logic              irq
);
  localparam int unsigned N  = num_cnt(WIDE_CNT);
  localparam int unsigned CW = cnt_bits(WIDE_CNT);

  logic              run;
  logic [N-1:0]      cnt_en;
  logic [N-1:0]      irq_mask;
  logic [N-1:0]      irq_stat;
  filt_t             filt;
  logic [N-1:0][7:0] codes;
  logic [N-1:0]      wrap;
  logic [N-1:0]      inc;
  logic [N-1:0]      wr_lo;
  logic [N-1:0]      wr_hi;
  logic [N-1:0][63:0] cnt_val;
  logic              pass;
  logic              in_cnt;
  logic [255:0]      ev_ext;
  logic [31:0]       rd_mux;

  assign ev_ext = 256'(ev_pulse);
  assign in_cnt = (reg_addr[ADDR_W-1:8] == CNT_PAGE) &&
                  (32'(reg_addr[7:3]) < N) && (reg_addr[1:0] == 2'b00);

  evctr_regs #(.N(N)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .wrap(wrap), .run(run), .cnt_en(cnt_en),
    .irq_mask(irq_mask), .irq_stat(irq_stat), .filt(filt), .codes(codes)
  );

  evctr_filter u_filter (
    .filt(filt), .src_id(src_id), .trace_tag(trace_tag), .pass(pass)
  );

  for (genvar i = 0; i < N; i++) begin : g_cnt
    assign inc[i]   = run && cnt_en[i] && (codes[i] != CODE_NONE) &&
                      ev_ext[codes[i]] && pass;
    assign wr_lo[i] = reg_wr && in_cnt && (reg_addr[7:3] == 5'(i)) && !reg_addr[2];
    assign wr_hi[i] = reg_wr && in_cnt && (reg_addr[7:3] == 5'(i)) &&  reg_addr[2];

    evctr_counter #(.CW(CW)) u_counter (
      .clk(clk), .rst(rst), .inc(inc[i]), .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]),
      .wdata(reg_wdata), .value(cnt_val[i]), .wrap(wrap[i])
    );

    // R4
    code_none_chk: assert property (@(posedge clk) disable iff (rst)
      (codes[i] == CODE_NONE && !wr_lo[i] && !wr_hi[i]) |=> $stable(cnt_val[i]));
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      OFS_RUN:  rd_mux[0]     = run;
      OFS_CEN:  rd_mux[N-1:0] = cnt_en;
      OFS_MASK: rd_mux[N-1:0] = irq_mask;
      OFS_STAT: rd_mux[N-1:0] = irq_stat;
      OFS_FILT: rd_mux = {filt.tag_en, filt.id_msk, 3'b000, filt.id_cmd,
                          3'b000, filt.id_en, 2'b00};
      default:  rd_mux = '0;
    endcase
    for (int i = 0; i < N; i++) begin
      if (reg_addr == OFS_SEL + ADDR_W'(4 * (i / 4)))
        rd_mux[8*(i%4) +: 8] = codes[i];
      if (in_cnt && reg_addr[7:3] == 5'(i))
        rd_mux = reg_addr[2] ? cnt_val[i][63:32] : cnt_val[i][31:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      irq <= |(irq_stat & ~irq_mask);
    end
  end

  // R9
  mask_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (&irq_mask) |=> !irq);

  // R3
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !(reg_wr && in_cnt)) |=> $stable(cnt_val));
endmodule

// File: tb/evctr_top_bench.sv
`timescale 1ns/1ps
module evctr_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [63:0] ev_pulse = '0;
  logic [10:0] src_id = '0;
  logic        trace_tag = 1'b0;
  logic [31:0] rdata_n, rdata_w;
  logic        irq_n, irq_w;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evctr_top #(.WIDE_CNT(1'b0), .EV_W(64)) u_evctr_top (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(rdata_n),
    .ev_pulse(ev_pulse), .src_id(src_id), .trace_tag(trace_tag), .irq(irq_n)
  );

  evctr_top #(.WIDE_CNT(1'b1), .EV_W(64)) u_evctr_top_wide (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(rdata_w),
    .ev_pulse(ev_pulse), .src_id(src_id), .trace_tag(trace_tag), .irq(irq_w)
  );

  // filter word, source id, tag, expected increment (R10, R11)
  localparam int NV = 10;
  localparam logic [31:0] TB_FW  [NV] = '{32'h0000_0000, 32'h7FF0_48C4, 32'h7FF0_48C4,
    32'h7000_48C4, 32'h7000_48C4, 32'h8000_0000, 32'h8000_0000, 32'hFFF0_48C4,
    32'hFFF0_48C4, 32'h0000_48C4};
  localparam logic [10:0] TB_SRC [NV] = '{11'h555, 11'h123, 11'h124, 11'h1FF, 11'h223,
    11'h000, 11'h000, 11'h123, 11'h123, 11'h6AB};
  localparam logic        TB_TAG [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
    1'b0, 1'b1, 1'b0};
  localparam logic [31:0] TB_EXP [NV] = '{32'd1, 32'd1, 32'd0, 32'd1, 32'd0, 32'd0,
    32'd1, 32'd0, 32'd1, 32'd1};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] vn, output logic [31:0] vw);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    vn = rdata_n; vw = rdata_w;
  endtask

  task automatic pulse(input logic [63:0] ev);
    @(negedge clk);
    ev_pulse = ev;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] vn, vw;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(12'h100, vn, vw); check("R1 cnt0", vn, 0); check("R1 cnt0 wide", vw, 0);
    rd(12'h000, vn, vw); check("R1 run", vn, 0);
    rd(12'h004, vn, vw); check("R1 enable", vn, 0);
    rd(12'h00C, vn, vw); check("R1 status", vn, 0);
    rd(12'h008, vn, vw); check("R1 mask", vn, 32'h0000FFFF); check("R1 mask wide", vw, 32'h000000FF);
    rd(12'h040, vn, vw); check("R1 sel", vn, 32'hFFFFFFFF); check("R1 sel wide", vw, 32'hFFFFFFFF);
    check("R1 irq", {31'd0, irq_n}, 0);

    // R10 R11 table walk on counter 0 (code 5)
    wr(12'h000, 32'h1);
    wr(12'h004, 32'h1);
    wr(12'h040, 32'hFFFFFF05);
    for (int e = 0; e < NV; e++) begin
      wr(12'h014, TB_FW[e]);
      wr(12'h100, 32'h0);
      src_id = TB_SRC[e]; trace_tag = TB_TAG[e];
      pulse(64'h20);
      rd(12'h100, vn, vw);
      check($sformatf("R10/R11 vec%0d", e), vn, TB_EXP[e]);
      check($sformatf("R10/R11 vec%0d wide", e), vw, TB_EXP[e]);
    end
    src_id = '0; trace_tag = 1'b0;

    // R10 filter readback
    wr(12'h014, 32'hFFFFFFFF);
    rd(12'h014, vn, vw); check("R10 filter fields", vn, 32'hFFF1FFC4);
    wr(12'h014, 32'h0);

    // R3 enables
    wr(12'h100, 32'h0);
    wr(12'h000, 32'h0);
    pulse(64'h20);
    rd(12'h100, vn, vw); check("R3 run off", vn, 0);
    wr(12'h000, 32'h1); wr(12'h004, 32'h0);
    pulse(64'h20);
    rd(12'h100, vn, vw); check("R3 enable off", vn, 0);

    // R2 consecutive counting
    wr(12'h004, 32'h1);
    @(negedge clk); ev_pulse = 64'h20;
    repeat (3) @(negedge clk);
    ev_pulse = '0;
    rd(12'h100, vn, vw); check("R2 three events", vn, 3); check("R2 three events wide", vw, 3);

    // R5 write beats increment
    @(negedge clk);
    ev_pulse = 64'h20; reg_wr = 1'b1; reg_addr = 12'h100; reg_wdata = 32'h100;
    @(negedge clk);
    ev_pulse = '0; reg_wr = 1'b0;
    rd(12'h100, vn, vw); check("R5 write priority", vn, 32'h100); check("R5 write priority wide", vw, 32'h100);

    // R4 packing and null codes
    wr(12'h004, 32'hFFFF);
    wr(12'h044, 32'h0A400807);
    pulse(64'h100);
    rd(12'h128, vn, vw); check("R4 cnt5 code8", vn, 1); check("R4 cnt5 code8 wide", vw, 1);
    rd(12'h120, vn, vw); check("R4 cnt4 idle", vn, 0);
    pulse('1);
    rd(12'h120, vn, vw); check("R4 cnt4", vn, 1);
    rd(12'h128, vn, vw); check("R4 cnt5", vn, 2);
    rd(12'h130, vn, vw); check("R4 code out of range", vn, 0); check("R4 code out of range wide", vw, 0);
    rd(12'h138, vn, vw); check("R4 cnt7", vw, 1);
    rd(12'h108, vn, vw); check("R4 code FF", vn, 0);

    // R6 R7 rollover
    wr(12'h040, 32'hFFFF0605);
    wr(12'h004, 32'h2);
    wr(12'h108, 32'hFFFFFFFF);
    wr(12'h10C, 32'hFFFFFFFF);
    rd(12'h10C, vn, vw); check("R6 upper ignored", vn, 32'h0000FFFF); check("R6 wide full", vw, 32'hFFFFFFFF);
    wr(12'h008, 32'hFFFFFFFD);
    check("R9 irq idle", {31'd0, irq_n}, 0);
    pulse(64'h40);
    rd(12'h108, vn, vw); check("R7 low zero", vn, 0); check("R7 low zero wide", vw, 0);
    rd(12'h10C, vn, vw); check("R7 high zero", vn, 0); check("R7 high zero wide", vw, 0);
    rd(12'h00C, vn, vw); check("R7 status", vn, 2); check("R7 status wide", vw, 2);
    check("R9 irq raised", {31'd0, irq_n}, 1); check("R9 irq raised wide", {31'd0, irq_w}, 1);

    // R8 clear
    wr(12'h010, 32'h0);
    rd(12'h00C, vn, vw); check("R8 zero write", vn, 2);
    wr(12'h010, 32'h2);
    rd(12'h00C, vn, vw); check("R8 cleared", vn, 0);
    check("R9 irq dropped", {31'd0, irq_n}, 0);

    // R9 mask
    wr(12'h008, 32'hFFFFFFFF);
    wr(12'h108, 32'hFFFFFFFF); wr(12'h10C, 32'hFFFFFFFF);
    pulse(64'h40);
    rd(12'h00C, vn, vw); check("R9 masked status", vn, 2);
    check("R9 masked irq", {31'd0, irq_n}, 0);
    wr(12'h008, 32'hFFFFFFFD);
    rd(12'h00C, vn, vw);
    check("R9 unmasked irq", {31'd0, irq_n}, 1);

    // R8 set wins over clear
    wr(12'h010, 32'h2);
    wr(12'h108, 32'hFFFFFFFF); wr(12'h10C, 32'hFFFFFFFF);
    @(negedge clk);
    ev_pulse = 64'h40; reg_wr = 1'b1; reg_addr = 12'h010; reg_wdata = 32'h2;
    @(negedge clk);
    ev_pulse = '0; reg_wr = 1'b0;
    rd(12'h00C, vn, vw); check("R8 set wins", vn, 2); check("R8 set wins wide", vw, 2);

    // R12 unmapped
    rd(12'h0FC, vn, vw); check("R12 unmapped", vn, 0);
    rd(12'h048, vn, vw); check("R12 no sel reg wide", vw, 0);

    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule